// File: doc/BRIEF.md
# SMBus Indexed Block-Access Target

This block is a slave-only SMBus target for a small bank of eight byte-wide registers. It does not run on SCL. It oversamples SCL and SDA on a fast system clock, passes both lines through a synchronizer, and detects SCL edges and the START and STOP conditions from the synchronized levels. The target drives no SDA level of its own. It drives an output-enable that the pad uses to pull the open-drain line low.

The block answers one fixed 7-bit address, 0x69, which gives 0xD2 for writes and 0xD3 for reads.

- **Block write:** the host sends the start index, then a byte count, then that many data bytes. Each data byte lands in the next register.
- **Block read:** the host sends the start index, issues a repeated START, then sends the read address. The target replies with the number of registers left up to the end of the bank, followed by register contents from the stored index onward.

Register storage lives outside the block, behind a plain port made of an index, write data, a write strobe and combinational read data.

The host must hold each SCL phase, and the SDA setup before each SCL rise, for at least SYNC_STAGES+3 system clocks. With a system clock of a few tens of MHz this covers 400 kHz fast-mode traffic.

Top module: `smb_blk_target`

## Requirements
- R1: While rst_n is low and after it rises, sda_oe is 0, reg_we is 0 and reg_addr is 0.
- R2: An address byte of 0xD2 (write) or 0xD3 (read), MSB first, is ACKed by driving sda_oe high in the ninth clock. Any other address byte is NACKed, and the block then ignores the bus until the next START.
- R3: In a write, the address, index and non-zero count bytes are each ACKed. Each data byte is ACKed and stored through reg_addr/reg_wdata/reg_we at the current index.
- R4: After each stored or returned data byte the index advances by one, wrapping from 7 to 0.
- R5: A write count byte of 0x00 is NACKed, no register is written, and the block ignores the bus until the next START.
- R6: Data bytes beyond the announced count are NACKed and not written.
- R7: A read first sets the index with a write-addressed phase, then takes a repeated START and 0xD3. The target then sends a count byte of 8 minus the index, followed by register data from that index, all MSB first.
- R8: When the host NACKs a byte sent by the target, the target releases SDA, so further clocked bytes read as 0xFF.
- R9: A START at any point aborts the current transfer and restarts address reception. A STOP at any point returns the block to idle.
- R10: sda_oe changes only while the synchronized SCL is low.
- R11: reg_we is a single-cycle pulse, given exactly once per accepted data byte.
- R12: The index byte is taken modulo 8, using its three low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 3 | Register index |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_rdata | input | 8 | Read data for reg_addr, combinational |

## Verification
Every target response is due a few system clocks after the SCL edge that triggers it. The two synchronizer stages and the edge register put ACK and transmit drive roughly four cycles after SCL falls, which is far inside the twelve-cycle low phase the host model uses. The bench therefore samples SDA in the middle of the SCL high phase, where the level has long been settled. Register contents are compared only once a STOP and a few more cycles have passed, and the write strobes are counted on falling clock edges, so a pulse landing at any cycle inside the byte is caught exactly once.

// File: rtl/smb_blk_pkg.sv
`timescale 1ns/1ps
package smb_blk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_OFFS,
      ST_WCNT,
      ST_WDATA,
      ST_RCNT,
      ST_RDATA
   } smb_st_e;

   function automatic logic st_is_tx(input smb_st_e s);
      return (s == ST_RCNT) || (s == ST_RDATA);
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] ff;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= RST_VAL;
            else        ff <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= {STAGES{RST_VAL}};
            else        ff <= {ff[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = ff[STAGES-1];

endmodule

// File: rtl/smb_bus_cond.sv
`timescale 1ns/1ps
module smb_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/smb_proto_fsm.sv
`timescale 1ns/1ps
module smb_proto_fsm
   import smb_blk_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 8,
   localparam int        IDX_W    = $clog2(NUM_REGS),
   localparam int        CNT_W    = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   output logic             sda_oe,
   output logic [IDX_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   input  logic [7:0]       reg_rdata
);

   smb_st_e          st, st_nxt;
   logic [3:0]       bcnt;
   logic [7:0]       sr;
   logic [7:0]       rem;
   logic             ack_q;
   logic             inc_pend;
   logic [IDX_W-1:0] idx;

   logic [7:0]       rx_byte;
   logic             tx_st;
   logic [CNT_W-1:0] rd_count;
   logic [7:0]       tx_first;

   assign rx_byte  = {sr[6:0], sda_lvl};
   assign tx_st    = st_is_tx(st);
   assign rd_count = CNT_W'(NUM_REGS) - {1'b0, idx};
   assign tx_first = (st == ST_RCNT) ? 8'(rd_count) : reg_rdata;
   assign reg_addr = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         st_nxt    <= ST_IDLE;
         bcnt      <= '0;
         sr        <= '0;
         rem       <= '0;
         ack_q     <= 1'b0;
         inc_pend  <= 1'b0;
         idx       <= '0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (start_det) begin
            st       <= ST_ADDR;
            bcnt     <= '0;
            sda_oe   <= 1'b0;
            ack_q    <= 1'b0;
            inc_pend <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            bcnt     <= '0;
            sda_oe   <= 1'b0;
            inc_pend <= 1'b0;
         end else if (st != ST_IDLE) begin
            if (scl_rise) begin
               if (bcnt == 4'd8) begin
                  // ninth clock: acknowledge slot
                  bcnt     <= '0;
                  inc_pend <= 1'b0;
                  if (inc_pend) idx <= idx + 1'b1;
                  if (tx_st && sda_lvl) st <= ST_IDLE;
                  else                  st <= st_nxt;
               end else begin
                  bcnt <= bcnt + 4'd1;
                  if (!tx_st) sr <= rx_byte;
                  if (bcnt == 4'd7) begin
                     unique case (st)
                        ST_ADDR: begin
                           if (rx_byte[7:1] == DEV_ADDR) begin
                              ack_q  <= 1'b1;
                              st_nxt <= rx_byte[0] ? ST_RCNT : ST_OFFS;
                           end else begin
                              ack_q  <= 1'b0;
                              st_nxt <= ST_IDLE;
                           end
                        end
                        ST_OFFS: begin
                           ack_q  <= 1'b1;
                           idx    <= rx_byte[IDX_W-1:0];
                           st_nxt <= ST_WCNT;
                        end
                        ST_WCNT: begin
                           if (rx_byte == 8'd0) begin
                              ack_q  <= 1'b0;
                              st_nxt <= ST_IDLE;
                           end else begin
                              ack_q  <= 1'b1;
                              rem    <= rx_byte;
                              st_nxt <= ST_WDATA;
                           end
                        end
                        ST_WDATA: begin
                           if (rem != 8'd0) begin
                              ack_q     <= 1'b1;
                              rem       <= rem - 8'd1;
                              reg_we    <= 1'b1;
                              reg_wdata <= rx_byte;
                              inc_pend  <= 1'b1;
                              st_nxt    <= ST_WDATA;
                           end else begin
                              ack_q  <= 1'b0;
                              st_nxt <= ST_IDLE;
                           end
                        end
                        ST_RCNT: begin
                           ack_q  <= 1'b0;
                           st_nxt <= ST_RDATA;
                        end
                        ST_RDATA: begin
                           ack_q    <= 1'b0;
                           inc_pend <= 1'b1;
                           st_nxt   <= ST_RDATA;
                        end
                        default: begin
                           ack_q  <= 1'b0;
                           st_nxt <= ST_IDLE;
                        end
                     endcase
                  end
               end
            end else if (scl_fall) begin
               if (bcnt == 4'd8) begin
                  sda_oe <= ack_q;
               end else if (tx_st) begin
                  if (bcnt == 4'd0) begin
                     sr     <= tx_first;
                     sda_oe <= ~tx_first[7];
                  end else begin
                     sda_oe <= ~sr[3'(4'd7 - bcnt)];
                  end
               end else begin
                  sda_oe <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/smb_blk_target.sv
`timescale 1ns/1ps
module smb_blk_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scl_i,
   input  logic                        sda_i,
   output logic                        sda_oe,
   output logic [$clog2(NUM_REGS)-1:0] reg_addr,
   output logic [7:0]                  reg_wdata,
   output logic                        reg_we,
   input  logic [7:0]                  reg_rdata
);

   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 128 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two between 2 and 128");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] raw_lines, syn_lines;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic [IDX_W-1:0] idx_o;

   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sync
         smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_lines[g]),
            .q_o   (syn_lines[g])
         );
      end
   endgenerate

   assign scl_s = syn_lines[0];
   assign sda_s = syn_lines[1];

   smb_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe),
      .reg_addr  (idx_o),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   assign reg_addr = idx_o;

endmodule

// File: rtl/smb_blk_target_chk.sv
`timescale 1ns/1ps
module smb_blk_target_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             sda_oe,
   input logic             reg_we,
   input logic [IDX_W-1:0] reg_addr
);

   // R10: the SDA drive only moves in the SCL low phase
   p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));

   // R11: the write strobe never lasts two cycles
   p_we_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R3: no register write while the target pulls SDA
   p_we_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !sda_oe);

   // R4: the index moves only on SCL-high events
   p_idx_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_addr) |-> $past(scl_s));

   // R9: a START leaves SDA released
   p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

endmodule

bind smb_blk_target smb_blk_target_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .sda_oe    (sda_oe),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr)
);

// File: tb/sim_smb_blk_target.sv
`timescale 1ns/1ps
module sim_smb_blk_target;

   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic       sda_line;

   logic [7:0] mem     [0:7];
   logic [7:0] exp_mem [0:7];
   logic [7:0] wbuf    [0:15];

   int nchk = 0;
   int nfail = 0;
   int wecnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   smb_blk_target u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
      end
   end
   assign reg_rdata = mem[reg_addr];

   always @(negedge clk) if (reg_we) wecnt++;

   task automatic check(input string req, input int act, input int expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
   endtask

   task automatic bit_slot(input logic b, output logic seen);
      sda_m = b; q(); scl_m = 1'b1; q(); seen = sda_line; q(); scl_m = 1'b0; q();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      logic s;
      for (int i = 7; i > 7 - n; i--) bit_slot(b[i], s);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
      bit_slot(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_slot(1'b1, s);
         b[i] = s;
      end
      bit_slot(~give_ack, s);
      sda_m = 1'b1;
   endtask

   function automatic int exp_count(input logic [7:0] off);
      return 8 - int'(off[2:0]);
   endfunction

   task automatic cmp_mem(input string req);
      for (int r = 0; r < 8; r++) check(req, int'(mem[r]), int'(exp_mem[r]));
   endtask

   task automatic wr_txn(input logic [7:0] off, input logic [7:0] cnt, input int nb);
      int  base;
      int  expw;
      logic a, ea;
      base = wecnt;
      bus_start();
      send_byte(8'hD2, a); check("R2", int'(a), 1);
      send_byte(off, a);   check("R3", int'(a), 1);
      send_byte(cnt, a);   check("R5", int'(a), int'(cnt != 0));
      for (int i = 0; i < nb; i++) begin
         send_byte(wbuf[i], a);
         ea = (cnt != 0) && (i < int'(cnt));
         check(ea ? "R3" : "R6", int'(a), int'(ea));
         if (ea) exp_mem[(int'(off[2:0]) + i) % 8] = wbuf[i];
      end
      bus_stop();
      repeat (4) @(negedge clk);
      expw = (cnt == 0) ? 0 : ((nb < int'(cnt)) ? nb : int'(cnt));
      check("R11", wecnt - base, expw);
      cmp_mem("R4");
   endtask

   task automatic rd_txn(input logic [7:0] off, input int nr);
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD2, a); check("R2", int'(a), 1);
      send_byte(off, a);   check("R7", int'(a), 1);
      bus_start();
      send_byte(8'hD3, a); check("R2", int'(a), 1);
      recv_byte(1'b1, b);  check("R7", int'(b), exp_count(off));
      for (int i = 0; i < nr; i++) begin
         recv_byte(i < nr - 1, b);
         check((int'(off[2:0]) + i >= 8) ? "R4" : "R7", int'(b),
               int'(exp_mem[(int'(off[2:0]) + i) % 8]));
      end
      recv_byte(1'b0, b);  check("R8", int'(b), 8'hFF);
      bus_stop();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic a;
      logic [7:0] b;
      int base;
      void'($urandom(32'd24681357));
      for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      check("R1", int'(sda_oe), 0);
      check("R1", int'(reg_we), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1", int'(sda_oe), 0);
      check("R1", int'(reg_addr), 0);

      // R2: foreign address ignored
      base = wecnt;
      bus_start();
      send_byte(8'hA4, a); check("R2", int'(a), 0);
      send_byte(8'h00, a); check("R2", int'(a), 0);
      send_byte(8'h01, a); check("R2", int'(a), 0);
      bus_stop();
      check("R2", wecnt - base, 0);

      // R3: plain write
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_txn(8'h00, 8'd3, 3);
      // R4: wrap from last register to 0
      wbuf[0] = 8'hA6; wbuf[1] = 8'hA7; wbuf[2] = 8'hA0; wbuf[3] = 8'hA1;
      wr_txn(8'h06, 8'd4, 4);
      // R5: zero count
      wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
      wr_txn(8'h02, 8'd0, 2);
      // R6: surplus bytes
      wbuf[0] = 8'h5A; wbuf[1] = 8'h5B; wbuf[2] = 8'hC0; wbuf[3] = 8'hC1;
      wr_txn(8'h03, 8'd2, 4);
      // R12: index modulo 8
      wbuf[0] = 8'h9D;
      wr_txn(8'hF9, 8'd1, 1);
      check("R12", int'(mem[1]), 8'h9D);
      // R7 / R8: reads, one wrapping
      rd_txn(8'h05, 3);
      rd_txn(8'h07, 3);
      rd_txn(8'h00, 8);

      // R9: STOP in the middle of a block write
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h03, a); send_byte(8'd4, a);
      send_byte(8'h71, a); check("R9", int'(a), 1);
      exp_mem[3] = 8'h71;
      bus_stop();
      repeat (4) @(negedge clk);
      cmp_mem("R9");
      // R9: START in the middle of a byte
      bus_start();
      send_byte(8'hD2, a); send_bits(8'h5A, 5);
      wbuf[0] = 8'h4C;
      wr_txn(8'h04, 8'd1, 1);
      check("R9", int'(mem[4]), 8'h4C);

      // mixed random traffic
      for (int k = 0; k < 12; k++) begin
         logic [7:0] off, cnt;
         int nb;
         off = 8'($urandom);
         cnt = 8'($urandom_range(1, 6));
         nb  = int'(cnt) + int'($urandom_range(0, 1));
         for (int i = 0; i < nb; i++) wbuf[i] = 8'($urandom);
         wr_txn(off, cnt, nb);
         rd_txn(8'($urandom), int'($urandom_range(1, 9)));
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule